// File: doc/BRIEF.md
# Time-Protected System Configuration Register

This block is an 8-bit memory-mapped configuration register for a small microcontroller. Each bit drives an enable or select line of some other part of the chip: converter power, converter clock source, interrupt edge sensing, oscillator restart delay, clock supervision and the watchdog timeout rate. Three of the bits can be rewritten at any time. Four protected bits are guarded while the part runs in normal mode. They accept a single write, and only during a short window that opens when reset is released. In special mode every implemented bit stays writable. One bit position has no storage and always reads as zero.

The block also times the exit from the STOP low-power state. A STOP-exit request loads a down-counter with either a long or a short delay, chosen by the delay-enable bit at the moment of the request. When the count runs out, the block raises a one-cycle resume strobe. Requests that arrive while a countdown is running are discarded.

Top module: `syscfg_guard`

## Requirements
- R1: The outputs follow the stored bits as follows: bit 7 drives `adc_power_en`, bit 6 drives `conv_clk_sel`, bit 5 drives `irq_edge_only`, bit 4 drives `osc_delay_en`, bit 3 drives `clkmon_en`, and bits 1:0 drive `cop_rate[1:0]`. `rd_data` shows the stored value.
- R2: After reset, the register reads 0x10. Only the delay-enable bit is set.
- R3: Bit 2 of `rd_data` is always 0, whatever value is written.
- R4: In normal mode (`special_mode`=0), a write to the protected bits 5, 4, 1 and 0 takes effect only if two conditions hold. It is sampled on one of the first 64 rising edges after `rst_n` goes high. It is also the first write since reset.
- R5: In normal mode, once the window has closed (64 edges have passed or an earlier write occurred), the protected bits keep their value. The free bits of the same write still update.
- R6: The free bits 7, 6 and 3 take `wr_data` on every write in either mode. The new value is visible one cycle after the sampling edge.
- R7: In special mode (`special_mode`=1), bits 7, 6, 5, 4, 3, 1 and 0 take every write, at any time and any number of times.
- R8: Suppose `stop_exit_req` is sampled while idle with the delay bit set. Then `resume_pulse` is high for exactly one cycle, in the cycle that follows the 4000th rising edge after the sampling edge.
- R9: With the delay bit clear at the time of the request, `resume_pulse` goes high for one cycle after the 4th rising edge following the sampling edge.
- R10: A `stop_exit_req` that arrives while a countdown is running is ignored. It neither restarts the countdown nor produces an extra resume pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| special_mode | input | 1 | 1 = special mode: all bits stay writable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value (bit 2 is zero) |
| stop_exit_req | input | 1 | Request to leave STOP |
| resume_pulse | output | 1 | One-cycle strobe when the wake-up delay ends |
| adc_power_en | output | 1 | Converter power enable |
| conv_clk_sel | output | 1 | Converter/EEPROM clock source select |
| irq_edge_only | output | 1 | External interrupt is edge-sensitive only |
| osc_delay_en | output | 1 | Long oscillator restart delay selected |
| clkmon_en | output | 1 | Clock monitor enable |
| cop_rate | output | 2 | Watchdog timeout rate select |

## Verification
The hardest cases to reach sit on the window boundary. A first write exactly on edge 63 must be accepted, and a first write exactly on edge 64 must lose its protected bits. A second write placed well inside the window must also be blocked. The bench reaches these with directed scenarios: it counts edges from the release of reset and places the first write on the chosen edge. Randomly timed writes in both modes fill in the rest of the space. For wake-up, a second request is injected a couple of cycles into each countdown. The bench then checks that the pulse arrives at the original time and never a second time.

// File: rtl/syscfg_pkg.sv
// Package: shared widths, bit positions and masks of the configuration register.
// Assumes an 8-bit register; the bit positions are fixed because the
// neighbouring blocks decode them.
package syscfg_pkg;
    localparam int REG_W        = 8;
    localparam int B_ADC_PWR    = 7;
    localparam int B_CLK_SEL    = 6;
    localparam int B_IRQ_EDGE   = 5;
    localparam int B_OSC_DLY    = 4;
    localparam int B_CLKMON     = 3;
    localparam int B_COP_HI     = 1;
    localparam int B_COP_LO     = 0;

    // bits writable at any time
    localparam logic [REG_W-1:0] FREE_MASK = 8'hC8;
    // bits that are write-once inside the post-reset window in normal mode
    localparam logic [REG_W-1:0] PROT_MASK = 8'h33;
    // bits that have storage at all
    localparam logic [REG_W-1:0] IMPL_MASK = FREE_MASK | PROT_MASK;
    localparam logic [REG_W-1:0] RESET_VAL = 8'h10;
endpackage

// File: rtl/syscfg_window.sv
// Module: post-reset protection window tracker.
// Counts rising edges since reset release, saturating at WINDOW_CYCLES, and
// remembers whether any register write has happened. The window is open
// while both the count is below the limit and no write has been seen.
// Assumes rst_n is synchronous and active low.
module syscfg_window #(
    parameter int WINDOW_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    output logic win_open
);
    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW_CYCLES);

    logic [CNT_W-1:0] edge_cnt;
    logic             wrote_once;

    // Count edges after reset, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (edge_cnt != LIMIT) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // Remember the first write since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote_once <= 1'b0;
        end else if (wr_en) begin
            wrote_once <= 1'b1;
        end
    end

    // Window is open only before the limit and before any write.
    always_comb begin
        win_open = (edge_cnt != LIMIT) && !wrote_once;
    end
endmodule

// File: rtl/syscfg_store.sv
// Module: register storage with a per-bit write qualifier.
// Free bits load on every write; protected bits load only in special mode
// or while the protection window is open; unimplemented bits are tied to 0.
// Assumes wr_en is a single-cycle-per-access strobe sampled on clk.
module syscfg_store
    import syscfg_pkg::*;
#(
    parameter logic [REG_W-1:0] FREE_BITS = FREE_MASK,
    parameter logic [REG_W-1:0] PROT_BITS = PROT_MASK,
    parameter logic [REG_W-1:0] RST_VALUE = RESET_VAL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             special_mode,
    input  logic             win_open,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_q
);
    logic prot_ok;

    // Protected bits may change in special mode or inside the window.
    always_comb begin
        prot_ok = special_mode || win_open;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (FREE_BITS[i]) begin : g_free
            // Free bit: load on any write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[i] <= RST_VALUE[i];
                end else if (wr_en) begin
                    cfg_q[i] <= wr_data[i];
                end
            end
        end else if (PROT_BITS[i]) begin : g_prot
            // Protected bit: load only when the qualifier allows it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[i] <= RST_VALUE[i];
                end else if (wr_en && prot_ok) begin
                    cfg_q[i] <= wr_data[i];
                end
            end
        end else begin : g_none
            // Unimplemented bit: constant zero.
            always_comb begin
                cfg_q[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/syscfg_wake.sv
// Module: STOP-exit delay timer.
// An idle request loads LONG_DELAY or SHORT_DELAY depending on long_sel,
// counts down one per clock and emits a one-cycle resume strobe on the edge
// where the count leaves 1. Requests while counting are dropped.
// Assumes both delays are at least 1.
module syscfg_wake #(
    parameter int LONG_DELAY  = 4000,
    parameter int SHORT_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic exit_req,
    input  logic long_sel,
    output logic resume
);
    localparam int DLY_W = $clog2(LONG_DELAY + 1);
    localparam logic [DLY_W-1:0] LONG_LD  = DLY_W'(LONG_DELAY);
    localparam logic [DLY_W-1:0] SHORT_LD = DLY_W'(SHORT_DELAY);

    logic [DLY_W-1:0] remain;
    logic             idle;

    // Timer is idle when nothing is left to count.
    always_comb begin
        idle = (remain == '0);
    end

    // Load on an idle request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (idle) begin
            if (exit_req) begin
                remain <= long_sel ? LONG_LD : SHORT_LD;
            end
        end else begin
            remain <= remain - 1'b1;
        end
    end

    // Strobe for one cycle when the last count is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume <= 1'b0;
        end else begin
            resume <= (remain == DLY_W'(1));
        end
    end
endmodule

// File: rtl/syscfg_guard.sv
// Module: top of the time-protected system configuration register.
// Joins the protection window, the bit storage and the STOP-exit timer, and
// fans the stored bits out to the decoded control lines.
// Assumes special_mode is static while out of reset.
module syscfg_guard
    import syscfg_pkg::*;
#(
    parameter int WINDOW_CYCLES = 64,
    parameter int LONG_DELAY    = 4000,
    parameter int SHORT_DELAY   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             special_mode,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             stop_exit_req,
    output logic             resume_pulse,
    output logic             adc_power_en,
    output logic             conv_clk_sel,
    output logic             irq_edge_only,
    output logic             osc_delay_en,
    output logic             clkmon_en,
    output logic [1:0]       cop_rate
);
    logic             win_open;
    logic [REG_W-1:0] cfg_q;

    syscfg_window #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .win_open(win_open)
    );

    syscfg_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .special_mode(special_mode),
        .win_open    (win_open),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cfg_q       (cfg_q)
    );

    syscfg_wake #(
        .LONG_DELAY (LONG_DELAY),
        .SHORT_DELAY(SHORT_DELAY)
    ) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .exit_req(stop_exit_req),
        .long_sel(cfg_q[B_OSC_DLY]),
        .resume  (resume_pulse)
    );

    // Decode the stored bits onto the control lines and the read bus.
    always_comb begin
        rd_data       = cfg_q;
        adc_power_en  = cfg_q[B_ADC_PWR];
        conv_clk_sel  = cfg_q[B_CLK_SEL];
        irq_edge_only = cfg_q[B_IRQ_EDGE];
        osc_delay_en  = cfg_q[B_OSC_DLY];
        clkmon_en     = cfg_q[B_CLKMON];
        cop_rate      = {cfg_q[B_COP_HI], cfg_q[B_COP_LO]};
    end
endmodule

// File: rtl/syscfg_guard_chk.sv
// Module: assertion checker for syscfg_guard, attached by bind.
// Observes the ports plus the internal window flag.
module syscfg_guard_chk
    import syscfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             special_mode,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             resume_pulse,
    input logic             adc_power_en,
    input logic             conv_clk_sel,
    input logic             irq_edge_only,
    input logic             osc_delay_en,
    input logic             clkmon_en,
    input logic [1:0]       cop_rate,
    input logic             win_open
);
    AST_OUTPUT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        {adc_power_en, conv_clk_sel, irq_edge_only, osc_delay_en, clkmon_en, cop_rate}
        == {rd_data[7:3], rd_data[1:0]}); // R1

    AST_BIT2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] == 1'b0); // R3

    AST_WINDOW_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> !win_open); // R4

    AST_LATE_PROT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !special_mode && !win_open)
        |=> ((rd_data & PROT_MASK) == ($past(rd_data) & PROT_MASK))); // R5

    AST_FREE_BITS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_data & FREE_MASK) == ($past(wr_data) & FREE_MASK))); // R6

    AST_SPECIAL_LOADS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && special_mode) |=> (rd_data == ($past(wr_data) & IMPL_MASK))); // R7

    AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse); // R8
endmodule

bind syscfg_guard syscfg_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .resume_pulse (resume_pulse),
    .adc_power_en (adc_power_en),
    .conv_clk_sel (conv_clk_sel),
    .irq_edge_only(irq_edge_only),
    .osc_delay_en (osc_delay_en),
    .clkmon_en    (clkmon_en),
    .cop_rate     (cop_rate),
    .win_open     (win_open)
);

// File: tb/syscfg_guard_tb.sv
`timescale 1ns/1ps
// Bench: fixed-seed random and directed stimulus against a bench-side model.
module syscfg_guard_tb;
    localparam int WIN  = 64;
    localparam int LONG = 4000;
    localparam int SHRT = 4;
    localparam logic [7:0] FREE = 8'hC8;
    localparam logic [7:0] PROT = 8'h33;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       stop_exit_req = 1'b0;
    logic       resume_pulse;
    logic       adc_power_en, conv_clk_sel, irq_edge_only, osc_delay_en, clkmon_en;
    logic [1:0] cop_rate;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model;
    int edges;
    bit written;

    always #2.5 clk = ~clk;

    syscfg_guard u_dut (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .stop_exit_req(stop_exit_req), .resume_pulse(resume_pulse),
        .adc_power_en(adc_power_en), .conv_clk_sel(conv_clk_sel),
        .irq_edge_only(irq_edge_only), .osc_delay_en(osc_delay_en),
        .clkmon_en(clkmon_en), .cop_rate(cop_rate)
    );

    function automatic logic [7:0] next_val(logic [7:0] cur, logic [7:0] d,
                                            bit spec, bit open);
        logic [7:0] r;
        r = (cur & ~FREE) | (d & FREE);
        if (spec || open) r = (r & ~PROT) | (d & PROT);
        return r;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        cmp(req, rd_data, model);
        cmp("R1", {adc_power_en, conv_clk_sel, irq_edge_only, osc_delay_en,
                   clkmon_en, 1'b0, cop_rate}, model);
        cmp("R3", rd_data[2], 1'b0);
    endtask

    task automatic do_reset(bit spec);
        @(negedge clk);
        rst_n = 1'b0; special_mode = spec; wr_en = 1'b0; stop_exit_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model = 8'h10; edges = 0; written = 0;
        cmp("R2", rd_data, 8'h10);
    endtask

    // One write cycle: drive at negedge, update model at the edge.
    task automatic step(bit w, logic [7:0] d, output string lbl);
        bit open;
        wr_en = w; wr_data = d;
        @(posedge clk);
        open = (edges < WIN) && !written;
        lbl = "R6";
        if (w) begin
            model = next_val(model, d, special_mode, open);
            written = 1;
            lbl = special_mode ? "R7" : (open ? "R4" : "R5");
        end
        if (edges < WIN) edges++;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Scenario with directed write indices (-1 = none) plus random writes.
    task automatic scenario(bit spec, int w1, int w2, bit rnd);
        string lbl;
        bit w;
        do_reset(spec);
        for (int c = 0; c < 100; c++) begin
            w = (c == w1) || (c == w2) || (rnd && ($urandom % 8 == 0));
            step(w, 8'($urandom), lbl);
            check_all(lbl);
        end
    endtask

    // Wake-up timing with a stray request two cycles in.
    task automatic run_wake(int n, string req);
        @(negedge clk);
        stop_exit_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stop_exit_req = 1'b0;
        for (int k = 1; k <= n + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            cmp(req, resume_pulse, (k == n));
            stop_exit_req = (k == 2) && (n > 3);
        end
        stop_exit_req = 1'b0;
        for (int k = 0; k < n + 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            cmp("R10", resume_pulse, 1'b0);
        end
    endtask

    initial begin
        string lbl;
        void'($urandom(32'd20240611));
        scenario(1'b0, 63, -1, 1'b0);   // R4 first write on last window edge
        scenario(1'b0, 64, 80, 1'b0);   // R5 first write just after window
        scenario(1'b0, 5, 10, 1'b0);    // R4/R5 second write inside window blocked
        scenario(1'b1, 2, 90, 1'b0);    // R7 repeated writes in special mode
        for (int s = 0; s < 6; s++) begin
            scenario(1'($urandom % 2), -1, -1, 1'b1);
        end
        // R8: long delay from reset value (delay bit set)
        do_reset(1'b0);
        run_wake(LONG, "R8");
        // R9: clear the delay bit in special mode, then short delay
        do_reset(1'b1);
        step(1'b1, 8'h00, lbl);
        check_all("R7");
        run_wake(SHRT, "R9");
        // R8 again after setting the bit back in special mode
        step(1'b1, 8'h10, lbl);
        check_all("R7");
        run_wake(LONG, "R8");
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end
endmodule